// File: doc/BRIEF.md
# Packet-to-byte framing encoder

This block turns a packet, presented as a ready/valid byte stream with start and end flags, into a framed and escaped byte stream for a serial shifter. Each packet goes out as a start marker, a channel marker and a channel number, then the payload. The end marker is placed in front of the final payload byte rather than after it. Payload bytes that match a framing character or a line-level character are replaced by an escape character followed by the byte with bit 5 inverted. Each of the two groups has its own escape character.

The output is valid on every cycle after reset. When there is nothing to send, the idle byte goes out. That includes gaps inside a packet while the input is starved. A static configuration input selects between byte granularity and word alignment. With word alignment on, idle bytes are inserted just before the end marker, so that the packet's final byte falls on the last byte lane of a 4-byte word. The alignment is counted over all output bytes accepted since reset. The serial shifter itself sits downstream and is not part of this block.

Top module: `pkt_byte_framer`

## Requirements
- R1: While reset is asserted, out_valid_o is 0. After reset, with no packet pending, out_valid_o is 1 and out_data_o is the idle byte 0x4A on every cycle.
- R2: A packet begins on the output with the three bytes 0x7A (start), 0x7C (channel marker), 0x00 (channel number). These are emitted when the input offers a byte with in_sop_i set.
- R3: A payload byte outside the sets {0x7A,0x7B,0x7C,0x7D} and {0x4A,0x4D} is forwarded unchanged, and payload order is preserved.
- R4: A payload byte in {0x7A,0x7B,0x7C,0x7D} is sent as 0x7D followed by the byte XOR 0x20.
- R5: A payload byte of 0x4A or 0x4D is sent as 0x4D followed by the byte XOR 0x20.
- R6: The end marker 0x7B is emitted immediately before the encoding of the last payload byte (the byte with in_eop_i set). If that byte needs escaping, the order is 0x7B, escape character, byte XOR 0x20.
- R7: While the input has no valid byte inside a packet, the idle byte 0x4A is emitted and no payload byte is lost.
- R8: With word_align_i = 1, idle bytes 0x4A are inserted directly before the end marker. The count is chosen so that the packet's final output byte has index 3 modulo 4. Index 0 is the first output byte accepted after reset.
- R9: With word_align_i = 0, no idle byte is inserted between the channel number and the end of the packet when the input is never starved.
- R10: While out_ready_i is 0, no input byte is taken and out_data_o holds its value. The accepted output sequence is the same as without backpressure.
- R11: A byte offered without in_sop_i while no packet is open is accepted and discarded, and the output stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_align_i | input | 1 | Static mode: 1 pads each packet to a 4-byte word end, 0 sends bytes unpadded |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high together with in_valid_i |
| in_data_i | input | 8 | Input payload byte |
| in_sop_i | input | 1 | First byte of a packet |
| in_eop_i | input | 1 | Last byte of a packet |
| out_valid_o | output | 1 | Output byte valid (high throughout after reset) |
| out_ready_i | input | 1 | Downstream takes the output byte |
| out_data_o | output | 8 | Framed output byte |

## Verification
The bench aims at the tail of the packet. It covers a last byte that needs escaping, a one-byte packet, and packets of every length modulo 4 in aligned mode. A design that put the end marker after the escape character, or after the last byte, would show up as a shifted tail. A design that counted padding from the packet start instead of the stream position would leave the final byte off lane 3. Escapes of both character groups are driven back to back and under a stall pattern on out_ready_i. A design that lost the pending escape half while stalled would drop or repeat a byte. Starved input inside a packet and stray bytes outside a packet are also driven. Either case would expose a design that emits non-idle filler or forwards stray data.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  localparam logic [7:0] FR_START   = 8'h7A;
  localparam logic [7:0] FR_END     = 8'h7B;
  localparam logic [7:0] FR_CHAN    = 8'h7C;
  localparam logic [7:0] FR_ESC     = 8'h7D;
  localparam logic [7:0] LN_IDLE    = 8'h4A;
  localparam logic [7:0] LN_ESC     = 8'h4D;
  localparam logic [7:0] CHAN_NUM   = 8'h00;
  localparam logic [7:0] FLIP_MASK  = 8'h20;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHAN,
    ST_CNUM,
    ST_BODY,
    ST_BXOR,
    ST_LESC,
    ST_LXOR,
    ST_LAST
  } fr_state_e;
endpackage

// File: rtl/pkt_esc_class.sv
module pkt_esc_class
  import pkt_framer_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       esc_o,
  output logic [7:0] esc_char_o
);
  always_comb begin
    esc_o      = 1'b0;
    esc_char_o = FR_ESC;
    unique case (byte_i)
      FR_START, FR_END, FR_CHAN, FR_ESC: esc_o = 1'b1;
      LN_IDLE, LN_ESC: begin
        esc_o      = 1'b1;
        esc_char_o = LN_ESC;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pkt_pad_check.sv
module pkt_pad_check #(
  parameter int WORD_BYTES = 4,
  localparam int POS_W = $clog2(WORD_BYTES)
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             tail_two_i,
  input  logic             align_i,
  output logic             pad_o
);
  // end marker at pos_i, then 1 or 2 tail bytes; last byte must hit the final lane
  logic [POS_W-1:0] after_last;
  assign after_last = pos_i + (tail_two_i ? POS_W'(3) : POS_W'(2));
  assign pad_o = align_i && (after_last != '0);
endmodule

// File: rtl/pkt_byte_framer.sv
module pkt_byte_framer
  import pkt_framer_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int POS_W = $clog2(WORD_BYTES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_align_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  input  logic       in_sop_i,
  input  logic       in_eop_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [7:0] out_data_o
);
  fr_state_e        state_q, state_d;
  logic             run_q;
  logic [POS_W-1:0] pos_q;
  logic             xfer;
  logic             need_esc;
  logic [7:0]       esc_char;
  logic             pad_now;

  pkt_esc_class u_esc (
    .byte_i     (in_data_i),
    .esc_o      (need_esc),
    .esc_char_o (esc_char)
  );

  pkt_pad_check #(.WORD_BYTES(WORD_BYTES)) u_pad (
    .pos_i      (pos_q),
    .tail_two_i (need_esc),
    .align_i    (word_align_i),
    .pad_o      (pad_now)
  );

  assign out_valid_o = run_q;
  assign xfer        = run_q && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pos_q   <= '0;
      state_q <= ST_IDLE;
    end else begin
      run_q   <= 1'b1;
      state_q <= state_d;
      if (xfer) pos_q <= pos_q + POS_W'(1);
    end
  end

  always_comb begin
    state_d    = state_q;
    out_data_o = LN_IDLE;
    in_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready_o = run_q && !in_sop_i;  // stray bytes are dropped
        if (in_valid_i && in_sop_i) begin
          out_data_o = FR_START;
          if (xfer) state_d = ST_CHAN;
        end
      end
      ST_CHAN: begin
        out_data_o = FR_CHAN;
        if (xfer) state_d = ST_CNUM;
      end
      ST_CNUM: begin
        out_data_o = CHAN_NUM;
        if (xfer) state_d = ST_BODY;
      end
      ST_BODY: begin
        if (in_valid_i) begin
          if (in_eop_i) begin
            if (!pad_now) begin
              out_data_o = FR_END;
              if (xfer) state_d = need_esc ? ST_LESC : ST_LAST;
            end
          end else if (need_esc) begin
            out_data_o = esc_char;
            if (xfer) state_d = ST_BXOR;
          end else begin
            out_data_o = in_data_i;
            in_ready_o = xfer;
          end
        end
      end
      ST_BXOR: begin
        out_data_o = in_data_i ^ FLIP_MASK;
        in_ready_o = xfer;
        if (xfer) state_d = ST_BODY;
      end
      ST_LESC: begin
        out_data_o = esc_char;
        if (xfer) state_d = ST_LXOR;
      end
      ST_LXOR: begin
        out_data_o = in_data_i ^ FLIP_MASK;
        in_ready_o = xfer;
        if (xfer) state_d = ST_IDLE;
      end
      ST_LAST: begin
        out_data_o = in_data_i;
        in_ready_o = xfer;
        if (xfer) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !out_ready_i) |=> ($stable(state_q) && $stable(pos_q)));

  assert_no_take_stalled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && state_q != ST_IDLE) |-> out_ready_i);

  assert_last_on_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && word_align_i && (state_q == ST_LAST || state_q == ST_LXOR))
      |-> (pos_q == {POS_W{1'b1}}));

  assert_end_then_tail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && state_q == ST_BODY && out_data_o == FR_END)
      |=> (state_q == ST_LAST || state_q == ST_LESC));

  assert_esc_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && state_q == ST_BODY && in_valid_i && !in_eop_i && need_esc)
      |=> (state_q == ST_BXOR && !$stable(pos_q)));
endmodule

// File: tb/pkt_byte_framer_tb.sv
module pkt_byte_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_align = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] cap[$];
  logic [7:0] pkt_q[$];
  logic [7:0] exp_q[$];

  logic       bp_en = 1'b0;
  logic [2:0] bp_cnt = '0;
  int         stall_seen = 0;
  int         stall_bad = 0;
  logic       prev_stall = 1'b0;
  logic       prev_valid_in = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always #5 clk = ~clk;

  always @(posedge clk) bp_cnt <= bp_cnt + 3'd1;
  assign out_ready = !bp_en || (bp_cnt[1:0] != 2'd1 && bp_cnt != 3'd6);

  pkt_byte_framer u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .word_align_i (word_align),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready),
    .in_data_i    (in_data),
    .in_sop_i     (in_sop),
    .in_eop_i     (in_eop),
    .out_valid_o  (out_valid),
    .out_ready_i  (out_ready),
    .out_data_o   (out_data)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) cap.push_back(out_data);
    if (rst_n && bp_en) begin
      if (prev_stall && prev_valid_in && in_valid) begin
        stall_seen++;
        if (out_data != prev_data) stall_bad++;
      end
      prev_stall    = out_valid && !out_ready;
      prev_valid_in = in_valid;
      prev_data     = out_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic bit is_fr(input logic [7:0] b);
    return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D;
  endfunction

  function automatic bit is_ln(input logic [7:0] b);
    return b == 8'h4A || b == 8'h4D;
  endfunction

  function automatic void push_enc(input logic [7:0] b);
    if (is_fr(b)) begin exp_q.push_back(8'h7D); exp_q.push_back(b ^ 8'h20); end
    else if (is_ln(b)) begin exp_q.push_back(8'h4D); exp_q.push_back(b ^ 8'h20); end
    else exp_q.push_back(b);
  endfunction

  task automatic send_pkt(input int gap);
    for (int i = 0; i < pkt_q.size(); i++) begin
      in_valid = 1'b1;
      in_data  = pkt_q[i];
      in_sop   = (i == 0);
      in_eop   = (i == pkt_q.size() - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  // compare the captured stream from start against the model of pkt_q
  task automatic check_stream(input string tag, input int start, input bit align, input bit strip);
    int  p, idx, tail;
    bit  ok;
    int  bad_act, bad_exp;
    logic [7:0] lastb;
    p = start;
    while (p < cap.size() && cap[p] != 8'h7A) p++;
    exp_q.delete();
    exp_q.push_back(8'h7A); exp_q.push_back(8'h7C); exp_q.push_back(8'h00);
    for (int i = 0; i < pkt_q.size() - 1; i++) push_enc(pkt_q[i]);
    lastb = pkt_q[pkt_q.size() - 1];
    tail  = (is_fr(lastb) || is_ln(lastb)) ? 2 : 1;
    if (align)
      while (((p + exp_q.size() + 1 + tail) % 4) != 0) exp_q.push_back(8'h4A);
    exp_q.push_back(8'h7B);
    push_enc(lastb);
    ok = 1; idx = p; bad_act = 0; bad_exp = 0;
    for (int k = 0; k < exp_q.size(); k++) begin
      while (strip && idx < cap.size() && cap[idx] == 8'h4A) idx++;
      if (idx >= cap.size()) begin
        if (ok) begin bad_act = -1; bad_exp = exp_q[k]; end
        ok = 0;
        break;
      end
      if (cap[idx] != exp_q[k] && ok) begin
        ok = 0; bad_act = cap[idx]; bad_exp = exp_q[k];
      end
      idx++;
    end
    chk(ok, tag, bad_act, bad_exp);
    if (align && !strip) chk(((idx - 1) % 4) == 3, {tag, " R8 lane"}, (idx - 1) % 4, 3);
    // link returns to idle after the packet
    chk(idx < cap.size() && cap[idx] == 8'h4A, {tag, " R1 idle after"},
        (idx < cap.size()) ? cap[idx] : -1, 8'h4A);
  endtask

  task automatic t_reset;
    #2;
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R1 valid after reset", out_valid, 1);
    chk(out_data == 8'h4A, "R1 idle byte", out_data, 8'h4A);
    @(posedge clk); #1;
  endtask

  task automatic run_pkt(input string tag, input bit align, input int gap);
    int s;
    word_align = align;
    s = cap.size();
    send_pkt(gap);
    check_stream(tag, s, align, gap > 0);
  endtask

  task automatic t_plain;
    pkt_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    run_pkt("R2 R3 R9 plain", 1'b0, 0);
  endtask

  task automatic t_fr_esc;
    pkt_q = '{8'h7A, 8'h01, 8'h7B, 8'h7C, 8'h7D, 8'h02};
    run_pkt("R4 framing escapes", 1'b0, 0);
  endtask

  task automatic t_ln_esc;
    pkt_q = '{8'h4A, 8'h4D, 8'h03, 8'h04};
    run_pkt("R5 line escapes", 1'b0, 0);
  endtask

  task automatic t_last_esc;
    pkt_q = '{8'h05, 8'h7D};
    run_pkt("R6 last framing escaped", 1'b0, 0);
    pkt_q = '{8'h06, 8'h4A};
    run_pkt("R6 last line escaped", 1'b0, 0);
    pkt_q = '{8'h99};
    run_pkt("R6 single byte", 1'b0, 0);
  endtask

  task automatic t_align;
    pkt_q = '{8'h99};
    run_pkt("R8 align len1", 1'b1, 0);
    pkt_q = '{8'h10, 8'h20};
    run_pkt("R8 align len2", 1'b1, 0);
    pkt_q = '{8'h10, 8'h20, 8'h30};
    run_pkt("R8 align len3", 1'b1, 0);
    pkt_q = '{8'h10, 8'h7A, 8'h30, 8'h7B};
    run_pkt("R8 align escaped tail", 1'b1, 0);
    pkt_q = '{8'h4D, 8'h20, 8'h30, 8'h40, 8'h4A};
    run_pkt("R8 align line tail", 1'b1, 0);
    pkt_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    run_pkt("R8 align len6", 1'b1, 0);
  endtask

  task automatic t_noalign;
    pkt_q = '{8'h01, 8'h02, 8'h03};
    run_pkt("R9 no pad len3", 1'b0, 0);
  endtask

  task automatic t_gaps;
    pkt_q = '{8'hA1, 8'h7C, 8'hA3, 8'h4D, 8'hA5};
    run_pkt("R7 starved input", 1'b0, 2);
  endtask

  task automatic t_backpressure;
    bp_en = 1'b1;
    pkt_q = '{8'h7A, 8'h4A, 8'h12, 8'h7D, 8'h34, 8'h4D, 8'h56, 8'h7B};
    run_pkt("R10 stalled align", 1'b1, 0);
    pkt_q = '{8'h21, 8'h7C, 8'h4A};
    run_pkt("R10 stalled noalign", 1'b0, 0);
    bp_en = 1'b0;
    chk(stall_seen > 0 && stall_bad == 0, "R10 data held while stalled", stall_bad, 0);
  endtask

  task automatic t_drop;
    int s;
    bit all_idle;
    int took;
    s = cap.size();
    took = 0;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 3); in_data = 8'h7A + 8'(i);
      @(negedge clk);
      if (in_ready) took++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_eop = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    all_idle = 1;
    for (int i = s; i < cap.size(); i++) if (cap[i] != 8'h4A) all_idle = 0;
    chk(took == 4, "R11 stray bytes accepted", took, 4);
    chk(all_idle, "R11 output idle on stray bytes", all_idle, 1);
    pkt_q = '{8'h42, 8'h43};
    run_pkt("R11 packet after stray", 1'b0, 0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_fr_esc();
    t_ln_esc();
    t_last_esc();
    t_align();
    t_noalign();
    t_gaps();
    t_backpressure();
    t_drop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule